// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block holds the alarm settings of a real-time clock: one register each for second, minute, hour, weekday, date, month and year. Every register is checked against the matching live BCD counter value that the clock supplies. Each field has its own enable bit. A field whose enable is clear takes no part in the decision. When every enabled field equals its counter at the same time, an alarm interrupt flag is raised.

Comparison happens only on the once-per-second update strobe. A two-state arming machine makes the flag fire once per start of a match, not once per strobe. The flag stays high until software clears it through the control register. There are two resets. Power-on reset clears all enable bits. Manual reset leaves the enables and the alarm values untouched and only restarts the flag and the arming machine. The alarm values themselves have no reset at all.

Software reaches the registers through a write port and a combinational read port. Addresses 0 to 5 are second, minute, hour, weekday, date and month. Each is laid out as {enable, BCD value}. Address 6 holds the year as two BCD digits. Address 7 is control: bit 0 is the year enable, bit 1 reads as the flag and clears it when written with 1.

The arming machine has two states. ST_WAIT means no match was seen on the last strobe. ST_HELD means the last strobe saw a match. There are two transitions: WAIT to HELD on a strobe with a match, which sets the flag, and HELD to WAIT on a strobe without a match. Either reset forces the machine to ST_WAIT.

Top module: `cal_alarm_match`

## Requirements
- R1: The date register (address 4) holds the enable in bit 7, the BCD tens digit in bits 5:4 and the BCD ones digit in bits 3:0. A written value reads back in the same positions.
- R2: Bits above each field's value width read as 0 and ignore writes. For example, date bit 6 reads 0, and weekday (address 3) keeps only bits 2:0 plus the enable in bit 7.
- R3: The date is compared with the date counter only while its enable is 1. With the enable at 0, any date counter value is ignored.
- R4: Second, minute, hour, weekday, date and month each have their own enable in bit 7 of their register. The year (address 6, bits 7:0) is enabled by bit 0 of the control register at address 7. Any single enabled field can raise the alarm on its own.
- R5: The alarm condition is true only when every enabled field equals its counter value at the same strobe.
- R6: With no field enabled, the alarm never fires.
- R7: The flag is set on a strobe where the alarm condition is true and the previous strobe's was not. It stays set until a write to address 7 with bit 1 at 1 clears it. A match that continues does not set it again. A set and a clear in the same cycle leave it set.
- R8: Counter values are compared only on the update strobe. A match with no strobe never sets the flag.
- R9: Power-on reset clears every enable and the flag. Manual reset clears the flag and the arming state but leaves every enable unchanged.
- R10: Alarm values are not touched by either reset. Written values read back unchanged after a power-on or a manual reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| sec_tick | input | 1 | Once-per-second update strobe |
| cnt_sec | input | 7 | Live BCD seconds |
| cnt_min | input | 7 | Live BCD minutes |
| cnt_hour | input | 6 | Live BCD hours |
| cnt_wday | input | 3 | Live weekday code |
| cnt_date | input | 6 | Live BCD date |
| cnt_mon | input | 5 | Live BCD month |
| cnt_year | input | 8 | Live BCD year |
| alarm_irq | output | 1 | Alarm interrupt flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a 3-bit address, which give seven alarm fields and the control register at address 7. With these values every field and the control word can be addressed, so the bench can enable each field alone, then mixed sets of fields, then none. It drives the two resets separately, so that the persistence of the enables and of the values can be seen through ordinary register reads. A behavioural model tracks the flag and the arming history every clock. This exposes re-firing on a continuing match, matches taken without a strobe, and a clear that wins over a set.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int NFIELD = 7;

    typedef enum logic {
        ST_WAIT,
        ST_HELD
    } arm_state_e;

    // Bits of each field that carry BCD value; all others read zero
    function automatic logic [7:0] field_mask(input int idx);
        logic [7:0] m;
        case (idx)
            0:       m = 8'h7F;  // seconds 00-59
            1:       m = 8'h7F;  // minutes 00-59
            2:       m = 8'h3F;  // hours
            3:       m = 8'h07;  // weekday code
            4:       m = 8'h3F;  // date 01-31
            5:       m = 8'h1F;  // month 01-12
            default: m = 8'hFF;  // year 00-99
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int NF = NFIELD,
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [AW-1:0]          rd_addr,
    input  logic                   flag,
    output logic [DW-1:0]          rd_data,
    output logic [NF-1:0][DW-1:0]  val,
    output logic [NF-1:0]          en,
    output logic                   clr_req
);

    localparam int            YEAR_IDX  = NF - 1;
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NF);
    localparam logic [AW-1:0] YEAR_ADDR = AW'(YEAR_IDX);

    for (genvar i = 0; i < NF; i++) begin : g_field
        localparam logic [AW-1:0] MY_ADDR = AW'(i);
        logic [DW-1:0] val_q;
        logic          en_q;

        // Value field: no reset of any kind
        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == MY_ADDR)
                val_q <= wr_data & DW'(field_mask(i));
        end

        if (i == YEAR_IDX) begin : g_ctrl_en
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n)
                    en_q <= 1'b0;
                else if (wr_en && wr_addr == CTRL_ADDR)
                    en_q <= wr_data[0];
            end
        end else begin : g_own_en
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n)
                    en_q <= 1'b0;
                else if (wr_en && wr_addr == MY_ADDR)
                    en_q <= wr_data[DW-1];
            end
        end

        assign val[i] = val_q;
        assign en[i]  = en_q;
    end

    assign clr_req = wr_en && (wr_addr == CTRL_ADDR) && wr_data[1];

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR)
            rd_data[1:0] = {flag, en[YEAR_IDX]};
        else if (rd_addr == YEAR_ADDR)
            rd_data = val[YEAR_IDX];
        else
            rd_data = {en[rd_addr], val[rd_addr][DW-2:0]};
    end

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
#(
    parameter int NF = NFIELD,
    parameter int DW = 8
) (
    input  logic [NF-1:0][DW-1:0] val,
    input  logic [NF-1:0][DW-1:0] cnt,
    input  logic [NF-1:0]         en,
    output logic                  all_match
);

    logic [NF-1:0] hit;

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        localparam logic [DW-1:0] MASK = DW'(field_mask(i));
        // A disabled field never blocks the match
        assign hit[i] = !en[i] || (((val[i] ^ cnt[i]) & MASK) == '0);
    end

    assign all_match = (&hit) && (|en);

endmodule

// File: rtl/cal_alarm_fsm.sv
module cal_alarm_fsm
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic all_match,
    input  logic clr_req,
    output logic irq
);

    arm_state_e state, nxt;
    logic       set_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_WAIT;
        else
            state <= nxt;
    end

    always_comb begin
        nxt      = state;
        set_flag = 1'b0;
        unique case (state)
            ST_WAIT: if (tick && all_match) begin
                nxt      = ST_HELD;
                set_flag = 1'b1;
            end
            ST_HELD: if (tick && !all_match) begin
                nxt = ST_WAIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (set_flag)
            irq <= 1'b1;
        else if (clr_req)
            irq <= 1'b0;
    end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          mrst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          sec_tick,
    input  logic [6:0]    cnt_sec,
    input  logic [6:0]    cnt_min,
    input  logic [5:0]    cnt_hour,
    input  logic [2:0]    cnt_wday,
    input  logic [5:0]    cnt_date,
    input  logic [4:0]    cnt_mon,
    input  logic [7:0]    cnt_year,
    output logic          alarm_irq
);

    localparam int NF = NFIELD;

    logic [NF-1:0][DW-1:0] alarm_val;
    logic [NF-1:0][DW-1:0] live_cnt;
    logic [NF-1:0]         alarm_en;
    logic                  clr_req;
    logic                  all_match;
    logic                  any_rst_n;

    assign any_rst_n = por_n & mrst_n;

    assign live_cnt[0] = DW'(cnt_sec);
    assign live_cnt[1] = DW'(cnt_min);
    assign live_cnt[2] = DW'(cnt_hour);
    assign live_cnt[3] = DW'(cnt_wday);
    assign live_cnt[4] = DW'(cnt_date);
    assign live_cnt[5] = DW'(cnt_mon);
    assign live_cnt[6] = DW'(cnt_year);

    cal_alarm_regs #(.NF(NF), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .flag    (alarm_irq),
        .rd_data (rd_data),
        .val     (alarm_val),
        .en      (alarm_en),
        .clr_req (clr_req)
    );

    cal_alarm_cmp #(.NF(NF), .DW(DW)) u_cmp (
        .val       (alarm_val),
        .cnt       (live_cnt),
        .en        (alarm_en),
        .all_match (all_match)
    );

    cal_alarm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (any_rst_n),
        .tick      (sec_tick),
        .all_match (all_match),
        .clr_req   (clr_req),
        .irq       (alarm_irq)
    );

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
    input logic       clk,
    input logic       por_n,
    input logic       mrst_n,
    input logic       sec_tick,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [2:0] rd_addr,
    input logic [7:0] rd_data,
    input logic [6:0] alarm_en,
    input logic       alarm_irq
);

    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        $rose(alarm_irq) |-> $past(sec_tick)); // R8

    AST_NONE_ENABLED_SILENT: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        (sec_tick && alarm_en == '0) |=> !$rose(alarm_irq)); // R6

    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        (wr_en && wr_addr == 3'd7 && wr_data[1] && !sec_tick) |=> !alarm_irq); // R7

    AST_MRST_KEEPS_EN: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n && !wr_en) |=> $stable(alarm_en)); // R9

    always @(negedge clk) begin
        if (!por_n)
            AST_POR_CLEARS_EN: assert (alarm_en == '0); // R9
        if (rd_addr == 3'd4)
            AST_DATE_RSVD_ZERO: assert (rd_data[6] !== 1'b1); // R2
    end

endmodule

bind cal_alarm_match cal_alarm_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .mrst_n    (mrst_n),
    .sec_tick  (sec_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .alarm_en  (alarm_en),
    .alarm_irq (alarm_irq)
);

// File: tb/cal_alarm_match_tb.sv
module cal_alarm_match_tb;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, mrst_n = 1'b1;
    logic       wr_en = 1'b0, sec_tick = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       alarm_irq;
    logic [7:0] cnt [7];

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cal_alarm_match u_dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick),
        .cnt_sec(cnt[0][6:0]), .cnt_min(cnt[1][6:0]), .cnt_hour(cnt[2][5:0]),
        .cnt_wday(cnt[3][2:0]), .cnt_date(cnt[4][5:0]), .cnt_mon(cnt[5][4:0]),
        .cnt_year(cnt[6]), .alarm_irq(alarm_irq)
    );

    function automatic logic [7:0] msk(input int i);
        case (i)
            0, 1: return 8'h7F;
            2, 4: return 8'h3F;
            3:    return 8'h07;
            5:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    logic [7:0] m_val [7];
    bit         m_wr [7];
    bit         m_en [7];
    bit         m_flag = 0, m_prev = 0;
    bit         mm_any, mm_all, mm_set;

    initial for (int i = 0; i < 7; i++) begin
        m_val[i] = '0; m_wr[i] = 0; m_en[i] = 0; cnt[i] = '0;
    end

    always @(posedge clk) begin
        mm_any = 0; mm_all = 1;
        for (int i = 0; i < 7; i++)
            if (m_en[i]) begin
                mm_any = 1;
                if (((m_val[i] ^ cnt[i]) & msk(i)) != 0) mm_all = 0;
            end
        mm_all = mm_all && mm_any;
        if (!por_n || !mrst_n) begin
            m_flag = 0; m_prev = 0;
        end else begin
            mm_set = 0;
            if (sec_tick) begin
                mm_set = mm_all && !m_prev;
                m_prev = mm_all;
            end
            if (mm_set) m_flag = 1;
            else if (wr_en && wr_addr == 3'd7 && wr_data[1]) m_flag = 0;
        end
        if (wr_en) begin
            if (wr_addr < 3'd7) begin
                m_val[wr_addr] = wr_data & msk(int'(wr_addr));
                m_wr[wr_addr] = 1;
                if (wr_addr < 3'd6) m_en[wr_addr] = wr_data[7];
            end else
                m_en[6] = wr_data[0];
        end
        if (!por_n) for (int i = 0; i < 7; i++) m_en[i] = 0;
        #1;
        chk("R7 model flag", {7'b0, alarm_irq}, {7'b0, m_flag});
        if (rd_addr == 3'd7)
            chk("R4 model ctrl", rd_data, {6'b0, m_flag, m_en[6]});
        else if (m_wr[rd_addr])
            chk("R1 model read", rd_data,
                rd_addr == 3'd6 ? m_val[6] : {m_en[rd_addr], m_val[rd_addr][6:0]});
    end

    task automatic cycle();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cycle();
        wr_en = 0;
    endtask

    task automatic tick();
        sec_tick = 1;
        cycle();
        sec_tick = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a; #1;
        chk(tag, rd_data, exp);
    endtask

    logic [7:0] vals [7] = '{8'h30, 8'h45, 8'h12, 8'h03, 8'h25, 8'h07, 8'h24};

    task automatic load_disabled();
        for (int i = 0; i < 7; i++) wr(3'(i), vals[i]);
        wr(3'd7, 8'h02);
        for (int i = 0; i < 7; i++) cnt[i] = vals[i];
    endtask

    initial begin
        repeat (3) cycle();
        chk("R9 irq in por", {7'b0, alarm_irq}, 8'h00);
        rd_chk("R9 ctrl in por", 3'd7, 8'h00);
        por_n = 1;
        cycle();

        // R1 / R2 layout
        wr(3'd4, 8'hA5);
        rd_chk("R1 date readback", 3'd4, 8'hA5);
        wr(3'd4, 8'hFF);
        rd_chk("R2 date bit6 zero", 3'd4, 8'hBF);
        wr(3'd3, 8'hFF);
        rd_chk("R2 weekday width", 3'd3, 8'h87);

        load_disabled();
        tick();
        chk("R6 nothing enabled", {7'b0, alarm_irq}, 8'h00);

        // R3 / R8 / R7 on the date field
        wr(3'd4, 8'hA5);
        cnt[4] = 8'h26; tick();
        chk("R3 date mismatch", {7'b0, alarm_irq}, 8'h00);
        cnt[4] = 8'h25; repeat (3) cycle();
        chk("R8 no strobe", {7'b0, alarm_irq}, 8'h00);
        tick();
        chk("R3 date match", {7'b0, alarm_irq}, 8'h01);
        tick();
        chk("R7 flag held", {7'b0, alarm_irq}, 8'h01);
        wr(3'd7, 8'h02);
        chk("R7 cleared", {7'b0, alarm_irq}, 8'h00);
        tick();
        chk("R7 no refire", {7'b0, alarm_irq}, 8'h00);
        cnt[4] = 8'h26; tick();
        cnt[4] = 8'h25; tick();
        chk("R7 new rise", {7'b0, alarm_irq}, 8'h01);
        // set and clear in one cycle: set wins
        cnt[4] = 8'h26; tick(); wr(3'd7, 8'h02);
        cnt[4] = 8'h25;
        sec_tick = 1; wr(3'd7, 8'h02); sec_tick = 0;
        chk("R7 set beats clear", {7'b0, alarm_irq}, 8'h01);

        // R3 ignore: date disabled, seconds enabled
        wr(3'd7, 8'h02);
        wr(3'd4, 8'h25); wr(3'd0, 8'hB0);
        cnt[0] = 8'h31; tick();
        cnt[0] = 8'h30; cnt[4] = 8'h11; tick();
        chk("R3 date ignored", {7'b0, alarm_irq}, 8'h01);

        // R4 every field alone
        for (int i = 0; i < 7; i++) begin
            load_disabled();
            if (i == 6) wr(3'd7, 8'h01);
            else wr(3'(i), vals[i] | 8'h80);
            for (int j = 0; j < 7; j++) if (j != i) cnt[j] = vals[j] ^ 8'h01;
            cnt[i] = vals[i] ^ 8'h01; tick();
            chk($sformatf("R4 field %0d mismatch", i), {7'b0, alarm_irq}, 8'h00);
            cnt[i] = vals[i]; tick();
            chk($sformatf("R4 field %0d match", i), {7'b0, alarm_irq}, 8'h01);
        end

        // R5 several fields together
        load_disabled();
        wr(3'd0, 8'hB0); wr(3'd1, 8'hC5); wr(3'd7, 8'h01);
        cnt[1] = 8'h46; tick();
        chk("R5 minute off", {7'b0, alarm_irq}, 8'h00);
        cnt[1] = 8'h45; cnt[6] = 8'h25; tick();
        chk("R5 year off", {7'b0, alarm_irq}, 8'h00);
        cnt[6] = 8'h24; tick();
        chk("R5 all match", {7'b0, alarm_irq}, 8'h01);

        // R9 / R10 manual reset
        mrst_n = 0; cycle(); mrst_n = 1; cycle();
        chk("R9 mrst clears flag", {7'b0, alarm_irq}, 8'h00);
        rd_chk("R9 mrst keeps sec en", 3'd0, 8'hB0);
        rd_chk("R10 mrst keeps min", 3'd1, 8'hC5);
        rd_chk("R9 mrst keeps year en", 3'd7, 8'h01);
        tick();
        chk("R9 rearmed after mrst", {7'b0, alarm_irq}, 8'h01);

        // R9 / R10 power-on reset
        por_n = 0; cycle(); por_n = 1; cycle();
        chk("R9 por clears flag", {7'b0, alarm_irq}, 8'h00);
        rd_chk("R10 por keeps sec", 3'd0, 8'h30);
        rd_chk("R10 por keeps min", 3'd1, 8'h45);
        rd_chk("R10 por keeps year", 3'd6, 8'h24);
        rd_chk("R9 por clears year en", 3'd7, 8'h00);
        tick();
        chk("R6 after por", {7'b0, alarm_irq}, 8'h00);

        cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule